// File: doc/BRIEF.md
# Enhanced Timer with Compare and PWM Output

This block is a 10-bit timer/counter that can count up or down. Three comparators watch the counter. Comparators A and B compare against full-width values. Comparator P compares against a coarse period value that is matched on the upper counter bits. Either A or P may be chosen to restart the count. A P value of zero gives the full 1024-count range instead, and the counter then wraps on overflow.

One output pin is shared by three operating modes:

- **Plain timer/counter:** the pin is held low.
- **Compare output:** the pin starts at a programmed level and toggles on each A match.
- **PWM:** the P comparator sets the period and the A value sets the duty. The control bit selects the active level, and a separate inversion bit is applied last.

All settings are plain input ports that are sampled every cycle. The counter value, one-cycle match flags for A, B and P, and a range-wrap flag are exported for the surrounding logic.

The block has no data stream, so it has no valid/ready handshake. Every pin is a level-sensitive control or status signal.

Top module: `enh_timer`

## Requirements
- R1: An active-low reset clears the counter and all four flags. When `en` is high and `cnt_down` is 0, the counter increments by one every clock unless a clear applies.
- R2: When `en` is low, the counter holds its value and no flag is raised.
- R3: When `cnt_down` is 1, the counter decrements. From 0 it reloads its limit: `cmp_a` when A clearing is selected, `{cmp_p, 7'b0}` when `cmp_p` is non-zero, and 1023 otherwise.
- R4: Outside PWM mode with `clr_sel_a` = 1, a cycle that counts up from a value equal to `cmp_a` loads 0.
- R5: With `clr_sel_a` = 0 (or in PWM mode) and `cmp_p` non-zero, a cycle that counts up from the value `{cmp_p, 7'b0}` loads 0. The count period is therefore `cmp_p`*128+1 cycles.
- R6: When `cmp_p` is 0, P clearing is replaced by overflow: the counter wraps 1023 to 0 (or 0 to 1023 when counting down), `ovf` pulses, and `match_p` never rises.
- R7: `match_a`, `match_b` and `match_p` are registered flags. A flag is high for one clock after an enabled cycle in which the counter equalled its compare value. A B match never changes the count.
- R8: In compare mode (`mode` = 1), the output level is reloaded from `out_ctl` on every clock in which `en` is low or the mode is different. It toggles on every A match.
- R9: In PWM mode (`mode` = 2), the pin shows the active level while the count is below `cmp_a`, and the opposite level otherwise. The active level is high when `out_ctl` = 1. `clr_sel_a` has no effect on the period.
- R10: In compare and PWM modes, `out_inv` = 1 inverts the pin relative to R8 and R9.
- R11: In timer mode (`mode` 0, with the reserved value 3 treated the same), the pin stays low regardless of `out_ctl` and `out_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable |
| mode | input | 2 | 0 timer, 1 compare output, 2 PWM, 3 treated as timer |
| out_ctl | input | 1 | Initial level (compare) or active level (PWM) |
| out_inv | input | 1 | Final pin inversion |
| cnt_down | input | 1 | 0 count up, 1 count down |
| clr_sel_a | input | 1 | 1 clears on A match, 0 clears on P match or overflow |
| cmp_a | input | 10 | Comparator A value / PWM duty |
| cmp_b | input | 10 | Comparator B value |
| cmp_p | input | 3 | Period value matched against the counter's top bits |
| tm_out | output | 1 | Timer output pin |
| count | output | 10 | Current counter value |
| match_a | output | 1 | One-cycle A match flag |
| match_b | output | 1 | One-cycle B match flag |
| match_p | output | 1 | One-cycle P match flag |
| ovf | output | 1 | One-cycle range-wrap flag |

## Verification
The embedded properties check the following on every clock:
- The count holds while `en` is low, and steps by one while it is high.
- The counter restarts after a selected A or P match.
- Flags only follow enabled cycles, and `match_p` stays silent with a zero period value.
- The pin is low in timer mode and matches the active level inside the PWM duty window.

The directed scenarios are needed for the things that depend on a sequence of events:
- The period lengths and pulse counts.
- The down-count reload values.
- Toggling in compare mode, and the reload of the initial level when counting is disabled.
- Duty ratios measured over a full PWM period with each setting of `out_ctl` and `out_inv`.

// File: rtl/enh_timer_pkg.sv
package enh_timer_pkg;
  typedef enum logic [1:0] {
    TM_TIMER = 2'd0,
    TM_CMP   = 2'd1,
    TM_PWM   = 2'd2,
    TM_RSVD  = 2'd3
  } tm_mode_e;
endpackage

// File: rtl/enh_timer_cmp.sv
module enh_timer_cmp #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [PER_W-1:0] cmp_p,
  output logic             hit_a,
  output logic             hit_b,
  output logic             hit_p,
  output logic             at_max,
  output logic             at_zero,
  output logic             below_a,
  output logic [CNT_W-1:0] p_limit
);
  localparam int LOW_W = CNT_W - PER_W;
  localparam int NFULL = 2;

  logic [CNT_W-1:0] full_val [NFULL];
  logic [NFULL-1:0] full_hit;

  assign full_val[0] = cmp_a;
  assign full_val[1] = cmp_b;

  // full-width equality comparators for A and B
  for (genvar gi = 0; gi < NFULL; gi++) begin : g_full
    assign full_hit[gi] = (count == full_val[gi]);
  end

  assign hit_a   = full_hit[0];
  assign hit_b   = full_hit[1];
  assign p_limit = {cmp_p, {LOW_W{1'b0}}};
  assign hit_p   = (cmp_p != '0) && (count == p_limit);
  assign at_max  = &count;
  assign at_zero = (count == '0);
  assign below_a = (count < cmp_a);
endmodule

// File: rtl/enh_timer_counter.sv
module enh_timer_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             down,
  input  logic             clr_up,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (en) begin
      if (down) begin
        count <= (count == '0) ? reload_val : count - 1'b1;
      end else begin
        count <= clr_up ? '0 : count + 1'b1;
      end
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && !clr_up) |=> (count == $past(count) + 1'b1));

  // R4
  up_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && clr_up) |=> (count == '0));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && down && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/enh_timer_out.sv
module enh_timer_out
  import enh_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  tm_mode_e   mode,
  input  logic       out_ctl,
  input  logic       out_inv,
  input  logic       hit_a,
  input  logic       below_a,
  output logic       tm_out
);
  logic cmp_lvl;
  logic raw_lvl;

  // compare-mode level: reload while idle, toggle on A match
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_lvl <= 1'b0;
    end else if (!en || mode != TM_CMP) begin
      cmp_lvl <= out_ctl;
    end else if (hit_a) begin
      cmp_lvl <= ~cmp_lvl;
    end
  end

  always_comb begin
    unique case (mode)
      TM_CMP:  raw_lvl = cmp_lvl;
      TM_PWM:  raw_lvl = below_a ? out_ctl : ~out_ctl;
      default: raw_lvl = 1'b0;
    endcase
  end

  assign tm_out = (mode == TM_CMP || mode == TM_PWM) ? (raw_lvl ^ out_inv) : 1'b0;

  // R8
  cmp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == TM_CMP && hit_a && $past(en) && $past(mode) == TM_CMP)
      |=> (cmp_lvl != $past(cmp_lvl)));

  // R8
  cmp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cmp_lvl == $past(out_ctl)));
endmodule

// File: rtl/enh_timer.sv
module enh_timer
  import enh_timer_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             out_ctl,
  input  logic             out_inv,
  input  logic             cnt_down,
  input  logic             clr_sel_a,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [PER_W-1:0] cmp_p,
  output logic             tm_out,
  output logic [CNT_W-1:0] count,
  output logic             match_a,
  output logic             match_b,
  output logic             match_p,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  tm_mode_e         mode_e;
  logic             hit_a, hit_b, hit_p, at_max, at_zero, below_a;
  logic [CNT_W-1:0] p_limit;
  logic             use_a;
  logic             clr_up;
  logic [CNT_W-1:0] reload_val;
  logic             wrap_evt;

  assign mode_e = tm_mode_e'(mode);

  enh_timer_cmp #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
    .count   (count),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .cmp_p   (cmp_p),
    .hit_a   (hit_a),
    .hit_b   (hit_b),
    .hit_p   (hit_p),
    .at_max  (at_max),
    .at_zero (at_zero),
    .below_a (below_a),
    .p_limit (p_limit)
  );

  // PWM always uses P for the period; elsewhere the select bit decides
  assign use_a      = clr_sel_a && (mode_e != TM_PWM);
  assign clr_up     = use_a ? hit_a : hit_p;
  assign reload_val = use_a ? cmp_a : ((cmp_p == '0) ? CNT_MAX : p_limit);
  assign wrap_evt   = cnt_down ? at_zero : at_max;

  enh_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .down       (cnt_down),
    .clr_up     (clr_up),
    .reload_val (reload_val),
    .count      (count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_a <= 1'b0;
      match_b <= 1'b0;
      match_p <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      match_a <= en && hit_a;
      match_b <= en && hit_b;
      match_p <= en && hit_p;
      ovf     <= en && wrap_evt;
    end
  end

  enh_timer_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .mode    (mode_e),
    .out_ctl (out_ctl),
    .out_inv (out_inv),
    .hit_a   (hit_a),
    .below_a (below_a),
    .tm_out  (tm_out)
  );

  // R7
  flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a || match_b || match_p || ovf) |-> $past(en));

  // R6
  no_p_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_p |-> ($past(cmp_p) != '0));

  // R11
  timer_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |-> !tm_out);

  // R9
  pwm_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && count < cmp_a) |-> (tm_out == (out_ctl ^ out_inv)));

  // R5
  p_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_down && !use_a && hit_p) |=> (count == '0));
endmodule

// File: tb/enh_timer_test.sv
module enh_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [1:0] mode;
  logic       out_ctl, out_inv, cnt_down, clr_sel_a;
  logic [9:0] cmp_a, cmp_b;
  logic [2:0] cmp_p;
  logic       tm_out;
  logic [9:0] count;
  logic       match_a, match_b, match_p, ovf;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  enh_timer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .out_ctl(out_ctl),
    .out_inv(out_inv), .cnt_down(cnt_down), .clr_sel_a(clr_sel_a),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_p(cmp_p), .tm_out(tm_out),
    .count(count), .match_a(match_a), .match_b(match_b),
    .match_p(match_p), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance n clock edges, returning at the following falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic defaults();
    mode = 2'd0; out_ctl = 1'b0; out_inv = 1'b0; cnt_down = 1'b0;
    clr_sel_a = 1'b0; cmp_a = 10'd0; cmp_b = 10'd1000; cmp_p = 3'd0;
  endtask

  task automatic t_reset();
    defaults();
    en = 1'b1;
    restart();
    check(count == 0 && !match_a && !match_b && !match_p && !ovf, "R1 reset",
          int'(count), 0);
  endtask

  task automatic t_up_and_hold();
    defaults();
    restart();
    en = 1'b1;
    step(10);
    check(count == 10, "R1 up count", int'(count), 10);
    en = 1'b0;
    begin
      int fl = 0;
      for (int i = 0; i < 5; i++) begin
        step(1);
        if (match_a || match_b || match_p || ovf) fl++;
      end
      check(count == 10, "R2 hold count", int'(count), 10);
      check(fl == 0, "R2 no flags", fl, 0);
    end
  endtask

  task automatic t_overflow();
    int nov = 0, np = 0, mx = 0;
    defaults();
    restart();
    en = 1'b1;
    for (int i = 0; i < 1030; i++) begin
      step(1);
      if (ovf) nov++;
      if (match_p) np++;
      if (int'(count) > mx) mx = int'(count);
    end
    check(nov == 1, "R6 ovf pulses", nov, 1);
    check(np == 0, "R6 no P match", np, 0);
    check(mx == 1023, "R6 full range", mx, 1023);
    check(count == 6, "R6 wrapped count", int'(count), 6);
  endtask

  task automatic t_p_clear();
    int np = 0, mx = 0;
    defaults();
    cmp_p = 3'd1;
    restart();
    en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (match_p) np++;
      if (int'(count) > mx) mx = int'(count);
    end
    check(mx == 128, "R5 P period top", mx, 128);
    check(np == 2, "R5 P match pulses", np, 2);
  endtask

  task automatic t_a_clear();
    int na = 0, mx = 0;
    defaults();
    clr_sel_a = 1'b1; cmp_a = 10'd20; cmp_p = 3'd1;
    restart();
    en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (match_a) na++;
      if (int'(count) > mx) mx = int'(count);
    end
    check(mx == 20, "R4 A clear top", mx, 20);
    check(na == 4, "R7 A match pulses", na, 4);
  endtask

  task automatic t_match_b();
    int nb = 0;
    defaults();
    cmp_b = 10'd7;
    restart();
    en = 1'b1;
    step(8);
    check(match_b == 1'b1 && count == 8, "R7 B flag timing", int'(match_b), 1);
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (match_b) nb++;
    end
    check(nb == 0 && count == 20, "R7 B one cycle, no clear", int'(count), 20);
  endtask

  task automatic t_down();
    defaults();
    cnt_down = 1'b1;
    restart();
    en = 1'b1;
    step(3);
    check(count == 1021, "R3 down from full", int'(count), 1021);
    defaults();
    cnt_down = 1'b1; clr_sel_a = 1'b1; cmp_a = 10'd10;
    restart();
    en = 1'b1;
    step(12);
    check(count == 10, "R3 down reload A", int'(count), 10);
    defaults();
    cnt_down = 1'b1; cmp_p = 3'd2;
    restart();
    en = 1'b1;
    step(2);
    check(count == 255, "R3 down reload P", int'(count), 255);
  endtask

  task automatic t_compare();
    defaults();
    mode = 2'd1; out_ctl = 1'b1; clr_sel_a = 1'b1; cmp_a = 10'd5;
    restart();
    step(2);
    check(tm_out == 1'b1, "R8 initial level", int'(tm_out), 1);
    en = 1'b1;
    step(5);
    check(tm_out == 1'b1, "R8 before match", int'(tm_out), 1);
    step(1);
    check(tm_out == 1'b0, "R8 toggled on A", int'(tm_out), 0);
    en = 1'b0;
    step(1);
    check(tm_out == 1'b1, "R8 reload on disable", int'(tm_out), 1);
    out_inv = 1'b1;
    #1;
    check(tm_out == 1'b0, "R10 compare invert", int'(tm_out), 0);
  endtask

  task automatic pwm_run(input bit ctl, input bit inv, input int exp, input string req);
    int hi = 0, mx = 0;
    defaults();
    mode = 2'd2; cmp_p = 3'd1; cmp_a = 10'd32; clr_sel_a = 1'b1;
    out_ctl = ctl; out_inv = inv;
    restart();
    en = 1'b1;
    #1;
    for (int i = 0; i < 129; i++) begin
      if (tm_out) hi++;
      if (int'(count) > mx) mx = int'(count);
      step(1);
    end
    check(hi == exp, req, hi, exp);
    check(mx == 128, "R9 period ignores clear select", mx, 128);
  endtask

  task automatic t_timer_pin();
    int hi = 0;
    defaults();
    out_ctl = 1'b1; out_inv = 1'b1; cmp_a = 10'd3;
    restart();
    en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (tm_out) hi++;
    end
    mode = 2'd3;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (tm_out) hi++;
    end
    check(hi == 0, "R11 timer pin low", hi, 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0;
    defaults();
    fork
      begin
        t_reset();
        t_up_and_hold();
        t_overflow();
        t_p_clear();
        t_a_clear();
        t_match_b();
        t_down();
        t_compare();
        pwm_run(1'b1, 1'b0, 32, "R9 active high duty");
        pwm_run(1'b0, 1'b0, 97, "R9 active low duty");
        pwm_run(1'b1, 1'b1, 97, "R10 PWM invert");
        t_timer_pin();
      end
      begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule